// File: doc/BRIEF.md
# Interrupt Enable and Mode Controller

This block keeps the interrupt-enable state of a small 8-bit processor core. It holds two enable flip-flops: a live one that gates maskable interrupts, and a saved copy that remembers the enable state across a non-maskable interrupt. It also holds the 2-bit interrupt response mode. The instruction decoder feeds it one-cycle command pulses: enable, disable, NMI accepted, maskable interrupt accepted, return from NMI, mode select (with the second opcode byte of the prefixed mode-select instruction), and the load of the accumulator from the interrupt-vector or refresh register.

The block produces three outputs. `irq_allowed` tells the interrupt sampler whether a maskable request may be taken. `im_mode` tells the acknowledge logic which response mode is active. `pv_flag` is the value the flag unit writes into the parity/overflow bit during the accumulator special loads. Acknowledge bus cycles and vector fetching belong to other blocks.

An enable takes effect only after the instruction that follows it completes. The decoder marks each instruction boundary with `instr_end`. The mode-select decode accepts the documented opcodes and also their undocumented aliases. The two ambiguous aliases map to mode 0, set by parameter `AMBIG_MODE`.

Top module: `irq_gate_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both flip-flops, the enable shadow and the mode are cleared. After reset, `irq_allowed`=0, `im_mode`=0 and `pv_flag`=0.
- R2: A `cmd_ei` pulse sets both flip-flops on the next edge. A `cmd_di` pulse clears both on the next edge.
- R3: `irq_allowed` is 1 only when the live flip-flop is set and no enable shadow is pending. The saved flip-flop alone never allows a maskable interrupt.
- R4: An `nmi_taken` pulse clears the live flip-flop and leaves the saved one unchanged.
- R5: An `nmi_return` pulse copies the saved flip-flop into the live one.
- R6: An `irq_taken` pulse clears both flip-flops.
- R7: While `ld_a_ir` is high, `pv_flag` equals the saved flip-flop. It is combinational in that same cycle. While `ld_a_ir` is low, `pv_flag` is 0.
- R8: With `im_set` high, opcode 0x46 or 0x66 selects mode 0 (`im_mode`=2'd0), 0x56 or 0x76 selects mode 1 (2'd1), and 0x5E or 0x7E selects mode 2 (2'd2). An opcode matches when (opcode & 0xC7) == 0x46, and bits [4:3] pick the mode. The mode register updates on the next edge.
- R9: With `im_set` high, the aliases 0x4E and 0x6E (bits [4:3] = 01) select mode 0 when `AMBIG_MODE`=0, the default.
- R10: With `im_set` high and an opcode outside the pattern of R8, the mode is unchanged. With `im_set` low, `im_opcode` has no effect.
- R11: After `cmd_ei`, `irq_allowed` stays 0 until an `instr_end` pulse arrives in a cycle after the enable with no new `cmd_ei` in it. `irq_allowed` rises after that edge. An `instr_end` in the same cycle as `cmd_ei` does not end the shadow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_ei | input | 1 | Enable-interrupts command pulse |
| cmd_di | input | 1 | Disable-interrupts command pulse |
| nmi_taken | input | 1 | Non-maskable interrupt accepted |
| irq_taken | input | 1 | Maskable interrupt accepted |
| nmi_return | input | 1 | Return-from-NMI command pulse |
| im_set | input | 1 | Mode-select command pulse |
| im_opcode | input | 8 | Second opcode byte of the mode-select instruction |
| ld_a_ir | input | 1 | Accumulator loaded from vector or refresh register |
| instr_end | input | 1 | Instruction boundary marker |
| irq_allowed | output | 1 | Maskable interrupt may be accepted |
| im_mode | output | 2 | Current interrupt mode (0, 1 or 2) |
| pv_flag | output | 1 | Value for the parity/overflow flag in the special loads |

## Verification
The checker assumes the decoder raises at most one of the command pulses (`cmd_ei`, `cmd_di`, `nmi_taken`, `irq_taken`, `nmi_return`, `im_set`, `ld_a_ir`) in any cycle. It also assumes `irq_taken` appears only while `irq_allowed` is high. It flags a violation of either assumption rather than defining a priority between commands. The random stimulus picks one command kind per cycle and turns a maskable acceptance into an idle cycle whenever the reference model says interrupts are not allowed. `instr_end` is toggled freely, so it lands both with and without an enable in the same cycle. Mode-select opcodes are drawn half from the eight matching values and half from the whole byte range.

// File: rtl/irqg_pkg.sv
// Shared types for the interrupt enable and mode controller.
// Assumes: the three interrupt modes fit a 2-bit code.
package irqg_pkg;

    localparam int MODE_W = 2;

    // Interrupt response mode codes
    typedef enum logic [MODE_W-1:0] {
        IMODE_0 = 2'd0,
        IMODE_1 = 2'd1,
        IMODE_2 = 2'd2
    } imode_t;

    // One-cycle commands that act on the enable flip-flops
    typedef struct packed {
        logic ei;
        logic di;
        logic nmi;
        logic irq;
        logic retn;
    } iff_cmd_t;

endpackage

// File: rtl/irqg_mode_dec.sv
// Decodes the second byte of the mode-select instruction.
// Assumes: the family is recognised by a fixed mask/pattern. Bits [4:3]
// pick the mode and the remaining free bit makes the aliases.
// AMBIG_MODE picks the mode given to the ambiguous selector 01.
module irqg_mode_dec
    import irqg_pkg::*;
#(
    parameter int OPC_W      = 8,
    parameter int AMBIG_MODE = 0
) (
    input  logic [OPC_W-1:0] opc,
    output logic             hit,
    output imode_t           mode
);

    localparam logic [OPC_W-1:0] FAM_MASK = OPC_W'('hC7);
    localparam logic [OPC_W-1:0] FAM_PAT  = OPC_W'('h46);
    localparam int               SEL_LO   = 3;
    localparam int               SEL_HI   = SEL_LO + MODE_W - 1;

    logic [MODE_W-1:0] sel;
    imode_t            alias_mode;

    assign sel = opc[SEL_HI:SEL_LO];

    // Parameter picks the meaning of the ambiguous alias
    generate
        if (AMBIG_MODE == 0) begin : g_alias_m0
            assign alias_mode = IMODE_0;
        end else begin : g_alias_m1
            assign alias_mode = IMODE_1;
        end
    endgenerate

    // Family match over the whole opcode byte
    always_comb begin
        hit = ((opc & FAM_MASK) == FAM_PAT);
    end

    // Selector field to mode code
    always_comb begin
        case (sel)
            2'd0:    mode = IMODE_0;
            2'd1:    mode = alias_mode;
            2'd2:    mode = IMODE_1;
            default: mode = IMODE_2;
        endcase
    end

endmodule

// File: rtl/irqg_mode_reg.sv
// Holds the current interrupt mode.
// Assumes: load is asserted only for a recognised mode-select opcode.
module irqg_mode_reg
    import irqg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  imode_t nxt,
    output imode_t cur
);

    // Mode register, mode 0 after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= IMODE_0;
        end else if (load) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/irqg_iff_pair.sv
// The live and saved interrupt-enable flip-flops plus the enable shadow.
// Assumes: at most one command per cycle. instr_end marks the last cycle
// of each instruction and may coincide with the enable command itself.
module irqg_iff_pair
    import irqg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  iff_cmd_t cmd,
    input  logic     instr_end,
    output logic     iff_live,
    output logic     iff_saved,
    output logic     ei_shadow
);

    // Live flip-flop: gates maskable acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff_live <= 1'b0;
        end else if (cmd.ei) begin
            iff_live <= 1'b1;
        end else if (cmd.di || cmd.nmi || cmd.irq) begin
            iff_live <= 1'b0;
        end else if (cmd.retn) begin
            iff_live <= iff_saved;
        end
    end

    // Saved flip-flop: survives NMI entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff_saved <= 1'b0;
        end else if (cmd.ei) begin
            iff_saved <= 1'b1;
        end else if (cmd.di || cmd.irq) begin
            iff_saved <= 1'b0;
        end
    end

    // Shadow: blocks acceptance until the next instruction ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ei_shadow <= 1'b0;
        end else if (cmd.ei) begin
            ei_shadow <= 1'b1;
        end else if (instr_end) begin
            ei_shadow <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_gate_ctl.sv
// Interrupt enable and mode controller top level.
// Takes decoded command pulses and exposes the maskable-interrupt gate,
// the current mode and the parity/overflow value for the special loads.
// Assumes: the decoder raises at most one command per cycle, and
// irq_taken only while irq_allowed is high.
module irq_gate_ctl
    import irqg_pkg::*;
#(
    parameter int OPC_W      = 8,
    parameter int AMBIG_MODE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_ei,
    input  logic             cmd_di,
    input  logic             nmi_taken,
    input  logic             irq_taken,
    input  logic             nmi_return,
    input  logic             im_set,
    input  logic [OPC_W-1:0] im_opcode,
    input  logic             ld_a_ir,
    input  logic             instr_end,
    output logic             irq_allowed,
    output logic [MODE_W-1:0] im_mode,
    output logic             pv_flag
);

    iff_cmd_t cmd;
    logic     iff1_q;
    logic     iff2_q;
    logic     shadow_q;
    logic     dec_hit;
    imode_t   dec_mode;
    imode_t   mode_q;

    // Gather the command pulses for the flip-flop pair
    always_comb begin
        cmd.ei   = cmd_ei;
        cmd.di   = cmd_di;
        cmd.nmi  = nmi_taken;
        cmd.irq  = irq_taken;
        cmd.retn = nmi_return;
    end

    irqg_iff_pair u_iff (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .instr_end (instr_end),
        .iff_live  (iff1_q),
        .iff_saved (iff2_q),
        .ei_shadow (shadow_q)
    );

    irqg_mode_dec #(
        .OPC_W      (OPC_W),
        .AMBIG_MODE (AMBIG_MODE)
    ) u_dec (
        .opc  (im_opcode),
        .hit  (dec_hit),
        .mode (dec_mode)
    );

    irqg_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (im_set && dec_hit),
        .nxt   (dec_mode),
        .cur   (mode_q)
    );

    // Output gate, mode and flag value
    always_comb begin
        irq_allowed = iff1_q && !shadow_q;
        im_mode     = mode_q;
        pv_flag     = ld_a_ir && iff2_q;
    end

endmodule

// File: rtl/irq_gate_ctl_chk.sv
// Property checker for irq_gate_ctl, attached by bind.
// Assumes: it sees the two flip-flops through the bind connection.
module irq_gate_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ei,
    input logic       cmd_di,
    input logic       nmi_taken,
    input logic       irq_taken,
    input logic       nmi_return,
    input logic       im_set,
    input logic [7:0] im_opcode,
    input logic       ld_a_ir,
    input logic       irq_allowed,
    input logic [1:0] im_mode,
    input logic       pv_flag,
    input logic       iff1,
    input logic       iff2
);

    // input assumption: one command per cycle
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ei, cmd_di, nmi_taken, irq_taken, nmi_return, im_set, ld_a_ir}));

    // input assumption: maskable acceptance only when allowed
    irq_when_allowed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |-> irq_allowed);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!iff1 && !iff2 && im_mode == 2'd0 && !irq_allowed));

    // R2
    ei_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ei |=> (iff1 && iff2));

    // R2
    di_clears_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_di |=> (!iff1 && !iff2));

    // R3
    allowed_needs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_allowed |-> iff1);

    // R4
    nmi_keeps_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_taken |=> (!iff1 && iff2 == $past(iff2)));

    // R5
    retn_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_return |=> (iff1 == $past(iff2)));

    // R6
    irq_clears_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (!iff1 && !iff2));

    // R7
    pv_after_ei_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a_ir && $past(cmd_ei)) |-> pv_flag);

    // R7
    pv_after_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_a_ir && $past(nmi_taken)) |-> (pv_flag == $past(iff2)));

    // R8
    mode_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_set && (im_opcode == 8'h5E || im_opcode == 8'h7E)) |=> (im_mode == 2'd2));

    // R9
    alias_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_set && (im_opcode == 8'h4E || im_opcode == 8'h6E)) |=> (im_mode == 2'd0));

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!im_set || (im_opcode & 8'hC7) != 8'h46) |=> $stable(im_mode));

    // R11
    ei_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ei |=> !irq_allowed);

endmodule

bind irq_gate_ctl irq_gate_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ei      (cmd_ei),
    .cmd_di      (cmd_di),
    .nmi_taken   (nmi_taken),
    .irq_taken   (irq_taken),
    .nmi_return  (nmi_return),
    .im_set      (im_set),
    .im_opcode   (im_opcode),
    .ld_a_ir     (ld_a_ir),
    .irq_allowed (irq_allowed),
    .im_mode     (im_mode),
    .pv_flag     (pv_flag),
    .iff1        (iff1_q),
    .iff2        (iff2_q)
);

// File: tb/test_irq_gate_ctl.sv
// Bench for irq_gate_ctl: directed corner cases plus seeded random commands,
// compared against a reference model built from the requirements.
module test_irq_gate_ctl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_ei, cmd_di, nmi_taken, irq_taken, nmi_return;
    logic       im_set, ld_a_ir, instr_end;
    logic [7:0] im_opcode;
    logic       irq_allowed;
    logic [1:0] im_mode;
    logic       pv_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    logic       m_iff1, m_iff2, m_shadow;
    logic [1:0] m_mode;

    irq_gate_ctl i_irq_gate_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_ei      (cmd_ei),
        .cmd_di      (cmd_di),
        .nmi_taken   (nmi_taken),
        .irq_taken   (irq_taken),
        .nmi_return  (nmi_return),
        .im_set      (im_set),
        .im_opcode   (im_opcode),
        .ld_a_ir     (ld_a_ir),
        .instr_end   (instr_end),
        .irq_allowed (irq_allowed),
        .im_mode     (im_mode),
        .pv_flag     (pv_flag)
    );

    always #2 clk = ~clk;

    // Command kinds used by the stimulus
    localparam int K_NONE = 0, K_EI = 1, K_DI = 2, K_NMI = 3, K_IRQ = 4,
                   K_RETN = 5, K_IM = 6, K_LDIR = 7;

    function automatic logic [1:0] exp_mode(logic [7:0] op, logic [1:0] cur);
        if ((op & 8'hC7) != 8'h46) return cur;
        case (op[4:3])
            2'd0, 2'd1: return 2'd0;
            2'd2:       return 2'd1;
            default:    return 2'd2;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        cmd_ei = 0; cmd_di = 0; nmi_taken = 0; irq_taken = 0; nmi_return = 0;
        im_set = 0; ld_a_ir = 0; instr_end = 0; im_opcode = 8'h00;
    endtask

    // One cycle: drive at the falling edge, update model at the rising edge,
    // check registered outputs at the next falling edge.
    task automatic step(int kind, logic [7:0] op, logic iend, string tag);
        cmd_ei     = (kind == K_EI);
        cmd_di     = (kind == K_DI);
        nmi_taken  = (kind == K_NMI);
        irq_taken  = (kind == K_IRQ);
        nmi_return = (kind == K_RETN);
        im_set     = (kind == K_IM);
        ld_a_ir    = (kind == K_LDIR);
        im_opcode  = op;
        instr_end  = iend;
        #1;
        chk({tag, " R7 pv"}, {7'd0, pv_flag}, {7'd0, (kind == K_LDIR) && m_iff2});
        @(posedge clk);
        case (kind)
            K_EI:   begin m_iff1 = 1; m_iff2 = 1; end
            K_DI:   begin m_iff1 = 0; m_iff2 = 0; end
            K_NMI:  m_iff1 = 0;
            K_IRQ:  begin m_iff1 = 0; m_iff2 = 0; end
            K_RETN: m_iff1 = m_iff2;
            K_IM:   m_mode = exp_mode(op, m_mode);
            default: ;
        endcase
        if (kind == K_EI) m_shadow = 1;
        else if (iend)    m_shadow = 0;
        @(negedge clk);
        clear_inputs();
        chk({tag, " R3/R11 allowed"}, {7'd0, irq_allowed}, {7'd0, m_iff1 && !m_shadow});
        chk({tag, " R8 mode"}, {6'd0, im_mode}, {6'd0, m_mode});
    endtask

    task automatic do_reset();
        rst_n = 0;
        clear_inputs();
        repeat (3) @(negedge clk);
        m_iff1 = 0; m_iff2 = 0; m_shadow = 0; m_mode = 2'd0;
        chk("R1 allowed in reset", {7'd0, irq_allowed}, 8'd0);
        chk("R1 mode in reset", {6'd0, im_mode}, 8'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 allowed after reset", {7'd0, irq_allowed}, 8'd0);
        chk("R1 mode after reset", {6'd0, im_mode}, 8'd0);
        chk("R1 pv after reset", {7'd0, pv_flag}, 8'd0);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] alias_ops [8];
        alias_ops = '{8'h46, 8'h66, 8'h56, 8'h76, 8'h5E, 8'h7E, 8'h4E, 8'h6E};
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2 / R11: enable with shadow, then boundary releases it
        step(K_EI, 8'h00, 1'b1, "R11 ei with own end");
        chk("R11 shadow holds", {7'd0, irq_allowed}, 8'd0);
        step(K_NONE, 8'h00, 1'b0, "R11 no boundary yet");
        chk("R11 still blocked", {7'd0, irq_allowed}, 8'd0);
        step(K_NONE, 8'h00, 1'b1, "R11 boundary");
        chk("R2 R11 allowed after boundary", {7'd0, irq_allowed}, 8'd1);
        step(K_LDIR, 8'h00, 1'b0, "R7 pv after ei");

        // R4 / R3: NMI keeps saved copy, live gate closes
        step(K_NMI, 8'h00, 1'b1, "R4 nmi");
        chk("R3 R4 saved alone does not allow", {7'd0, irq_allowed}, 8'd0);
        step(K_LDIR, 8'h00, 1'b0, "R4 R7 saved visible");
        // R5: return restores
        step(K_RETN, 8'h00, 1'b1, "R5 retn");
        chk("R5 restored allowed", {7'd0, irq_allowed}, 8'd1);
        // R6: maskable acceptance clears both
        step(K_IRQ, 8'h00, 1'b1, "R6 irq");
        step(K_RETN, 8'h00, 1'b1, "R6 retn after irq");
        chk("R6 saved cleared", {7'd0, irq_allowed}, 8'd0);
        // R2: disable
        step(K_EI, 8'h00, 1'b1, "R2 ei");
        step(K_DI, 8'h00, 1'b1, "R2 di");
        step(K_LDIR, 8'h00, 1'b0, "R2 pv after di");

        // R8 / R9: every family opcode
        foreach (alias_ops[i]) begin
            step(K_IM, 8'h5E, 1'b1, "R8 preset mode 2");
            step(K_IM, alias_ops[i], 1'b1, "R8 R9 family");
        end
        chk("R9 last alias gives mode 0", {6'd0, im_mode}, 8'd0);
        // R10: non-matching opcode and idle opcode
        step(K_IM, 8'h76, 1'b1, "R10 set mode 1");
        step(K_IM, 8'h47, 1'b1, "R10 non-matching");
        chk("R10 mode kept", {6'd0, im_mode}, 8'd1);
        step(K_NONE, 8'h5E, 1'b1, "R10 im_set low");
        chk("R10 opcode ignored", {6'd0, im_mode}, 8'd1);

        // R1: reset in the middle of activity
        step(K_EI, 8'h00, 1'b1, "R1 pre");
        step(K_NONE, 8'h00, 1'b1, "R1 pre");
        do_reset();

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            int         kind;
            logic [7:0] op;
            kind = $urandom_range(0, 7);
            if (kind == K_IRQ && !(m_iff1 && !m_shadow)) kind = K_NONE;
            if ($urandom_range(0, 1) == 1) op = alias_ops[$urandom_range(0, 7)];
            else                           op = 8'($urandom_range(0, 255));
            step(kind, op, 1'($urandom_range(0, 1)), "random");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule